// File: doc/BRIEF.md
# Ingress Flow Classifier and Router

This block sits behind the header parser of a small Ethernet switch. For every received frame it takes the destination MAC address, the VLAN ID, the priority code point and the number of the port the frame arrived on. It compares these against a table of flow rules. A rule that matches yields a forwarding decision: a set of egress ports, a copy-to-CPU bit, a discard bit, a flag that says the flow is time-critical, and the index of the ingress gate that polices it. A frame that matches no rule is handed back for ordinary bridge forwarding.

Rules are written one slot at a time through a simple write port. A single global bit picks the lookup key. When VLAN awareness is on, a rule compares MAC, VLAN ID and priority. When it is off, a rule compares the MAC alone. This bit cannot change while any rule is installed. Rules that would send a gated flow nowhere are refused. Any refused write raises an error flag for one cycle.

Top module: `vl_flow_classifier`

## Requirements
- R1: With VLAN awareness on (`vlan_aware`=1), a rule matches only when MAC, VLAN ID and priority all equal the header fields.
- R2: With VLAN awareness off (the reset value), a rule matches on the MAC alone, whatever the VLAN ID and priority.
- R3: A rule matches only if bit `hdr_port` of its ingress-port mask is set.
- R4: When several valid rules match, the one in the lowest slot decides the result.
- R5: The result appears with `res_vld`=1 in the cycle after `hdr_vld`, and only then. On a miss, `res_hit`=0, `res_bridge`=1, and every other result output is 0.
- R6: On a hit of a rule with no drop action, `res_port_mask` and `res_trap` copy the rule's egress mask and trap bit, so redirect and trap can combine.
- R7: The drop action of a rule wins. `res_drop`=1, and `res_port_mask` and `res_trap` are 0.
- R8: A hit whose rule has no drop action, an empty egress mask and no trap gives `res_drop`=1 with `res_nodest`=1. In every other case `res_nodest` is 0.
- R9: On a hit, `res_tc` equals the rule's gate-enable bit. `res_gate` carries the rule's gate index when that bit is 1, and 0 otherwise.
- R10: A write of a valid rule that has gate-enable set, an empty egress mask and trap clear is refused. `cfg_err` is 1 in the next cycle and the slot keeps its old content.
- R11: A mode write with a value different from `vlan_aware` is refused, with `cfg_err` set in the next cycle, while any slot holds a valid rule. A write of the same value, or any write with the table empty, is accepted without error.
- R12: An entry write with `ent_valid`=0 empties the slot, so the rule no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_we | input | 1 | Rule write strobe |
| ent_idx | input | 4 | Slot to write |
| ent_valid | input | 1 | Rule valid (0 empties the slot) |
| ent_mac | input | 48 | Rule destination MAC |
| ent_vid | input | 12 | Rule VLAN ID |
| ent_pcp | input | 3 | Rule priority |
| ent_in_mask | input | 5 | Ingress ports the rule applies to |
| ent_out_mask | input | 5 | Redirect egress ports |
| ent_trap | input | 1 | Copy to CPU |
| ent_drop | input | 1 | Discard |
| ent_gate_en | input | 1 | Rule uses an ingress gate |
| ent_gate_idx | input | 4 | Gate index |
| mode_we | input | 1 | Mode write strobe |
| mode_aware | input | 1 | New VLAN-awareness value |
| cfg_err | output | 1 | Previous write was refused |
| vlan_aware | output | 1 | Current VLAN-awareness mode |
| hdr_vld | input | 1 | Header fields valid |
| hdr_mac | input | 48 | Frame destination MAC |
| hdr_vid | input | 12 | Frame VLAN ID |
| hdr_pcp | input | 3 | Frame priority |
| hdr_port | input | 3 | Ingress port number |
| res_vld | output | 1 | Result valid |
| res_hit | output | 1 | A rule matched |
| res_bridge | output | 1 | Use bridge forwarding |
| res_port_mask | output | 5 | Egress port set |
| res_trap | output | 1 | Send to CPU |
| res_drop | output | 1 | Discard frame |
| res_nodest | output | 1 | Discarded for lack of destination |
| res_tc | output | 1 | Time-critical class |
| res_gate | output | 4 | Gate index |

## Verification
Random tables draw MACs, VLAN IDs and priorities from small pools, so several rules often match the same frame. Those lookups separate correct priority order (R4) from a wrong one, and separate the full key from the MAC-only key. They run under both modes, so a key compare that ignores the mode shows up. Directed cases keep all but one field equal to a rule: a VLAN ID or priority that differs, an ingress port outside the mask, a drop rule that also carries a mask, a rule that routes nowhere, and a gated rule. Each case tells one requirement's condition apart from its neighbours. Refused writes, both gate-only rules and mode changes with rules present, are each followed by a lookup that shows the table and the mode kept their old state.

// File: rtl/vlfc_pkg.sv
package vlfc_pkg;
    parameter int P_PORTS  = 5;
    parameter int P_PORT_W = $clog2(P_PORTS);
    parameter int P_GATE_W = 4;
    parameter int P_MAC_W  = 48;
    parameter int P_VID_W  = 12;
    parameter int P_PCP_W  = 3;

    typedef struct packed {
        logic                valid;
        logic [P_MAC_W-1:0]  mac;
        logic [P_VID_W-1:0]  vid;
        logic [P_PCP_W-1:0]  pcp;
        logic [P_PORTS-1:0]  in_mask;
        logic [P_PORTS-1:0]  out_mask;
        logic                trap;
        logic                drop;
        logic                gate_en;
        logic [P_GATE_W-1:0] gate_idx;
    } flow_ent_t;

    typedef struct packed {
        logic                vld;
        logic                hit;
        logic                bridge;
        logic                drop;
        logic                nodest;
        logic                trap;
        logic                tc;
        logic [P_PORTS-1:0]  mask;
        logic [P_GATE_W-1:0] gate;
    } flow_res_t;
endpackage

// File: rtl/vlfc_table.sv
module vlfc_table
    import vlfc_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ent_we,
    input  logic [IDX_W-1:0]                ent_idx,
    input  flow_ent_t                       ent_wr,
    input  logic                            mode_we,
    input  logic                            mode_aware,
    output flow_ent_t [N_ENTRIES-1:0]       tbl,
    output logic                            aware,
    output logic                            cfg_err
);
    typedef struct packed {
        flow_ent_t [N_ENTRIES-1:0] tbl;
        logic                      aware;
        logic                      err;
    } tbl_st_t;

    tbl_st_t st_d, st_q;
    logic    any_valid;
    logic    bad_ent;

    always_comb begin
        any_valid = 1'b0;
        for (int k = 0; k < N_ENTRIES; k++) begin
            any_valid = any_valid | st_q.tbl[k].valid;
        end
        bad_ent = ent_wr.valid && ent_wr.gate_en && !ent_wr.trap && (ent_wr.out_mask == '0);

        st_d     = st_q;
        st_d.err = 1'b0;
        if (ent_we) begin
            if (bad_ent) begin
                st_d.err = 1'b1;
            end else begin
                st_d.tbl[ent_idx] = ent_wr.valid ? ent_wr : '0;
            end
        end
        if (mode_we) begin
            if ((mode_aware != st_q.aware) && any_valid) begin
                st_d.err = 1'b1;
            end else begin
                st_d.aware = mode_aware;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl     = st_q.tbl;
    assign aware   = st_q.aware;
    assign cfg_err = st_q.err;

    // R11: the mode is frozen while a rule is installed
    a_r11_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        any_valid |=> $stable(aware));

    // R10: a gate-only rule write is flagged in the next cycle
    a_r10_gate_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_we && ent_wr.valid && ent_wr.gate_en && !ent_wr.trap && ent_wr.out_mask == '0)
        |=> cfg_err);

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
            // R10: no stored gated rule lacks a route
            a_r10_stored_routed: assert property (@(posedge clk) disable iff (!rst_n)
                (tbl[g].valid && tbl[g].gate_en) |-> (tbl[g].trap || tbl[g].out_mask != '0));
        end
    endgenerate
endmodule

// File: rtl/vlfc_match.sv
module vlfc_match
    import vlfc_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  flow_ent_t [N_ENTRIES-1:0] tbl,
    input  logic                      aware,
    input  logic [P_MAC_W-1:0]        mac,
    input  logic [P_VID_W-1:0]        vid,
    input  logic [P_PCP_W-1:0]        pcp,
    input  logic [P_PORT_W-1:0]       port,
    output logic                      hit,
    output logic [IDX_W-1:0]          idx
);
    logic [N_ENTRIES-1:0] m;
    logic                 port_ok;

    assign port_ok = (32'(port) < P_PORTS);

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
            logic key_ok;
            assign key_ok = (tbl[g].mac == mac) &&
                            (!aware || ((tbl[g].vid == vid) && (tbl[g].pcp == pcp)));
            assign m[g] = tbl[g].valid && key_ok && port_ok && tbl[g].in_mask[port];
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = N_ENTRIES - 1; k >= 0; k--) begin
            if (m[k]) begin
                hit = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/vl_flow_classifier.sv
module vl_flow_classifier
    import vlfc_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ent_we,
    input  logic [IDX_W-1:0]     ent_idx,
    input  logic                 ent_valid,
    input  logic [P_MAC_W-1:0]   ent_mac,
    input  logic [P_VID_W-1:0]   ent_vid,
    input  logic [P_PCP_W-1:0]   ent_pcp,
    input  logic [P_PORTS-1:0]   ent_in_mask,
    input  logic [P_PORTS-1:0]   ent_out_mask,
    input  logic                 ent_trap,
    input  logic                 ent_drop,
    input  logic                 ent_gate_en,
    input  logic [P_GATE_W-1:0]  ent_gate_idx,
    input  logic                 mode_we,
    input  logic                 mode_aware,
    output logic                 cfg_err,
    output logic                 vlan_aware,
    input  logic                 hdr_vld,
    input  logic [P_MAC_W-1:0]   hdr_mac,
    input  logic [P_VID_W-1:0]   hdr_vid,
    input  logic [P_PCP_W-1:0]   hdr_pcp,
    input  logic [P_PORT_W-1:0]  hdr_port,
    output logic                 res_vld,
    output logic                 res_hit,
    output logic                 res_bridge,
    output logic [P_PORTS-1:0]   res_port_mask,
    output logic                 res_trap,
    output logic                 res_drop,
    output logic                 res_nodest,
    output logic                 res_tc,
    output logic [P_GATE_W-1:0]  res_gate
);
    flow_ent_t                 wr_ent;
    flow_ent_t [N_ENTRIES-1:0] tbl;
    flow_ent_t                 sel;
    logic                      m_hit;
    logic [IDX_W-1:0]          m_idx;
    flow_res_t                 res_d, res_q;

    always_comb begin
        wr_ent          = '0;
        wr_ent.valid    = ent_valid;
        wr_ent.mac      = ent_mac;
        wr_ent.vid      = ent_vid;
        wr_ent.pcp      = ent_pcp;
        wr_ent.in_mask  = ent_in_mask;
        wr_ent.out_mask = ent_out_mask;
        wr_ent.trap     = ent_trap;
        wr_ent.drop     = ent_drop;
        wr_ent.gate_en  = ent_gate_en;
        wr_ent.gate_idx = ent_gate_idx;
    end

    vlfc_table #(.N_ENTRIES(N_ENTRIES)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_we     (ent_we),
        .ent_idx    (ent_idx),
        .ent_wr     (wr_ent),
        .mode_we    (mode_we),
        .mode_aware (mode_aware),
        .tbl        (tbl),
        .aware      (vlan_aware),
        .cfg_err    (cfg_err)
    );

    vlfc_match #(.N_ENTRIES(N_ENTRIES)) i_match (
        .tbl   (tbl),
        .aware (vlan_aware),
        .mac   (hdr_mac),
        .vid   (hdr_vid),
        .pcp   (hdr_pcp),
        .port  (hdr_port),
        .hit   (m_hit),
        .idx   (m_idx)
    );

    assign sel = tbl[m_idx];

    always_comb begin
        res_d     = '0;
        res_d.vld = hdr_vld;
        if (hdr_vld) begin
            if (!m_hit) begin
                res_d.bridge = 1'b1;
            end else begin
                res_d.hit  = 1'b1;
                res_d.tc   = sel.gate_en;
                res_d.gate = sel.gate_en ? sel.gate_idx : '0;
                if (sel.drop) begin
                    res_d.drop = 1'b1;
                end else if (sel.out_mask == '0 && !sel.trap) begin
                    res_d.drop   = 1'b1;
                    res_d.nodest = 1'b1;
                end else begin
                    res_d.mask = sel.out_mask;
                    res_d.trap = sel.trap;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_vld       = res_q.vld;
    assign res_hit       = res_q.hit;
    assign res_bridge    = res_q.bridge;
    assign res_port_mask = res_q.mask;
    assign res_trap      = res_q.trap;
    assign res_drop      = res_q.drop;
    assign res_nodest    = res_q.nodest;
    assign res_tc        = res_q.tc;
    assign res_gate      = res_q.gate;

    a_r5_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |=> res_vld);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_vld |=> !res_vld);
    a_r5_miss_bridges: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_bridge && !res_drop && !res_tc && res_port_mask == '0));
    a_r7_drop_clears_route: assert property (@(posedge clk) disable iff (!rst_n)
        res_drop |-> (res_port_mask == '0 && !res_trap));
    a_r8_nodest_is_drop: assert property (@(posedge clk) disable iff (!rst_n)
        res_nodest |-> (res_drop && res_hit));
endmodule

// File: tb/test_vl_flow_classifier.sv
module test_vl_flow_classifier;
    import vlfc_pkg::*;

    localparam int N = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ent_we = 1'b0;
    logic [3:0]          ent_idx = '0;
    logic                ent_valid = 1'b0;
    logic [47:0]         ent_mac = '0;
    logic [11:0]         ent_vid = '0;
    logic [2:0]          ent_pcp = '0;
    logic [4:0]          ent_in_mask = '0;
    logic [4:0]          ent_out_mask = '0;
    logic                ent_trap = 1'b0;
    logic                ent_drop = 1'b0;
    logic                ent_gate_en = 1'b0;
    logic [3:0]          ent_gate_idx = '0;
    logic                mode_we = 1'b0;
    logic                mode_aware = 1'b0;
    logic                cfg_err;
    logic                vlan_aware;
    logic                hdr_vld = 1'b0;
    logic [47:0]         hdr_mac = '0;
    logic [11:0]         hdr_vid = '0;
    logic [2:0]          hdr_pcp = '0;
    logic [2:0]          hdr_port = '0;
    logic                res_vld, res_hit, res_bridge, res_trap, res_drop, res_nodest, res_tc;
    logic [4:0]          res_port_mask;
    logic [3:0]          res_gate;

    vl_flow_classifier i_vl_flow_classifier (.*);

    always #2ns clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    flow_ent_t m_tbl [N];
    logic      m_aware = 1'b0;
    logic [47:0] mac_pool [4] = '{48'h42be249b7620, 48'h42be249b7621, 48'h0a0000000001, 48'hfeedface0002};

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [31:0] exp_lookup(logic [47:0] mac, logic [11:0] vid,
                                               logic [2:0] pcp, logic [2:0] port);
        flow_res_t r = '0;
        r.vld = 1'b1;
        r.bridge = 1'b1;
        for (int k = 0; k < N; k++) begin
            if (m_tbl[k].valid && m_tbl[k].mac == mac && m_tbl[k].in_mask[port] &&
                (!m_aware || (m_tbl[k].vid == vid && m_tbl[k].pcp == pcp))) begin
                r.bridge = 1'b0;
                r.hit = 1'b1;
                r.tc = m_tbl[k].gate_en;
                r.gate = m_tbl[k].gate_en ? m_tbl[k].gate_idx : '0;
                if (m_tbl[k].drop) r.drop = 1'b1;
                else if (m_tbl[k].out_mask == '0 && !m_tbl[k].trap) begin
                    r.drop = 1'b1;
                    r.nodest = 1'b1;
                end else begin
                    r.mask = m_tbl[k].out_mask;
                    r.trap = m_tbl[k].trap;
                end
                break;
            end
        end
        return 32'(r);
    endfunction

    function automatic logic [31:0] act_res();
        flow_res_t r;
        r.vld = res_vld; r.hit = res_hit; r.bridge = res_bridge; r.drop = res_drop;
        r.nodest = res_nodest; r.trap = res_trap; r.tc = res_tc;
        r.mask = res_port_mask; r.gate = res_gate;
        return 32'(r);
    endfunction

    task automatic lookup(string tag, logic [47:0] mac, logic [11:0] vid,
                          logic [2:0] pcp, logic [2:0] port);
        @(negedge clk);
        hdr_vld = 1'b1; hdr_mac = mac; hdr_vid = vid; hdr_pcp = pcp; hdr_port = port;
        @(negedge clk);
        hdr_vld = 1'b0;
        chk(tag, act_res(), exp_lookup(mac, vid, pcp, port));
    endtask

    task automatic wr_ent(string tag, int idx, flow_ent_t e);
        logic bad;
        @(negedge clk);
        ent_we = 1'b1; ent_idx = 4'(idx); ent_valid = e.valid; ent_mac = e.mac;
        ent_vid = e.vid; ent_pcp = e.pcp; ent_in_mask = e.in_mask; ent_out_mask = e.out_mask;
        ent_trap = e.trap; ent_drop = e.drop; ent_gate_en = e.gate_en; ent_gate_idx = e.gate_idx;
        bad = e.valid && e.gate_en && !e.trap && e.out_mask == '0;
        if (!bad) m_tbl[idx] = e.valid ? e : '0;
        @(negedge clk);
        ent_we = 1'b0;
        chk(tag, 32'(cfg_err), 32'(bad));
    endtask

    task automatic wr_mode(string tag, logic a);
        logic any = 1'b0;
        logic bad;
        for (int k = 0; k < N; k++) any |= m_tbl[k].valid;
        bad = (a != m_aware) && any;
        @(negedge clk);
        mode_we = 1'b1; mode_aware = a;
        if (!bad) m_aware = a;
        @(negedge clk);
        mode_we = 1'b0;
        chk(tag, {30'd0, cfg_err, vlan_aware}, {30'd0, bad, m_aware});
    endtask

    function automatic flow_ent_t mk(logic [47:0] mac, logic [11:0] vid, logic [2:0] pcp,
                                     logic [4:0] inm, logic [4:0] outm, logic trap,
                                     logic drop, logic gate, logic [3:0] gidx);
        flow_ent_t e;
        e.valid = 1'b1; e.mac = mac; e.vid = vid; e.pcp = pcp; e.in_mask = inm;
        e.out_mask = outm; e.trap = trap; e.drop = drop; e.gate_en = gate; e.gate_idx = gidx;
        return e;
    endfunction

    function automatic flow_ent_t rnd_ent();
        logic [31:0] r = $urandom;
        return mk(mac_pool[r[1:0]], 12'(1 + r[2]), 3'(r[3]), 5'(r[8:4]) | 5'b00001,
                  (r[11:9] == 0) ? 5'd0 : 5'(r[16:12]), r[17], (r[20:18] == 0),
                  r[21], 4'(r[25:22]));
    endfunction

    task automatic rnd_lookups(int cnt);
        for (int i = 0; i < cnt; i++) begin
            logic [31:0] r = $urandom;
            lookup("R1 R2 R3 R4 random", mac_pool[r[1:0]], 12'(1 + r[2]), 3'(r[3]),
                   3'(r[7:4] % 5));
        end
    endtask

    task automatic clear_all();
        for (int k = 0; k < N; k++) wr_ent("R12 clear", k, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250505));
        for (int k = 0; k < N; k++) m_tbl[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset state", {26'd0, res_vld, cfg_err, vlan_aware, res_hit, res_drop, res_bridge}, 32'd0);
        lookup("R5 empty table miss", mac_pool[0], 12'd1, 3'd0, 3'd0);
        @(negedge clk);
        chk("R5 no result without header", 32'(res_vld), 32'd0);

        // directed: unaware mode
        wr_ent("R6 redirect+trap", 0, mk(mac_pool[0], 12'd5, 3'd1, 5'b00100, 5'b01000, 1'b1, 1'b0, 1'b0, 4'd0));
        lookup("R2 unaware ignores VID/PCP", mac_pool[0], 12'd77, 3'd6, 3'd2);
        lookup("R3 port outside mask", mac_pool[0], 12'd5, 3'd1, 3'd1);
        wr_ent("R7 drop with mask", 1, mk(mac_pool[1], 12'd5, 3'd1, 5'b11111, 5'b00011, 1'b1, 1'b1, 1'b0, 4'd0));
        lookup("R7 drop overrides", mac_pool[1], 12'd5, 3'd1, 3'd4);
        wr_ent("R8 empty destination", 2, mk(mac_pool[2], 12'd5, 3'd1, 5'b11111, 5'b0, 1'b0, 1'b0, 1'b0, 4'd0));
        lookup("R8 no destination drop", mac_pool[2], 12'd5, 3'd1, 3'd0);
        wr_ent("R9 gated", 3, mk(mac_pool[3], 12'd5, 3'd1, 5'b11111, 5'b10000, 1'b0, 1'b0, 1'b1, 4'd9));
        lookup("R9 time-critical flag", mac_pool[3], 12'd5, 3'd1, 3'd3);
        wr_ent("R10 gate without route refused", 3, mk(mac_pool[3], 12'd5, 3'd1, 5'b11111, 5'b0, 1'b0, 1'b0, 1'b1, 4'd2));
        lookup("R10 slot unchanged", mac_pool[3], 12'd5, 3'd1, 3'd3);
        wr_ent("R4 shadow rule", 4, mk(mac_pool[0], 12'd5, 3'd1, 5'b00100, 5'b00001, 1'b0, 1'b1, 1'b0, 4'd0));
        lookup("R4 lowest slot wins", mac_pool[0], 12'd5, 3'd1, 3'd2);
        wr_mode("R11 change refused", 1'b1);
        lookup("R11 mode kept", mac_pool[0], 12'd99, 3'd1, 3'd2);
        wr_mode("R11 same value accepted", 1'b0);
        wr_ent("R12 empty slot", 0, '0);
        lookup("R12 cleared rule gone", mac_pool[0], 12'd5, 3'd1, 3'd2);

        // aware mode
        clear_all();
        wr_mode("R11 change with empty table", 1'b1);
        wr_ent("R1 rule", 5, mk(mac_pool[0], 12'd100, 3'd0, 5'b11111, 5'b00010, 1'b0, 1'b0, 1'b0, 4'd0));
        lookup("R1 full key hit", mac_pool[0], 12'd100, 3'd0, 3'd1);
        lookup("R1 VID differs", mac_pool[0], 12'd101, 3'd0, 3'd1);
        lookup("R1 PCP differs", mac_pool[0], 12'd100, 3'd3, 3'd1);

        // random tables, both modes
        for (int k = 0; k < N; k++) wr_ent("R10 random write", k, rnd_ent());
        rnd_lookups(300);
        wr_mode("R11 random locked", 1'b0);
        clear_all();
        wr_mode("R11 unlock", 1'b0);
        for (int k = 0; k < N; k++) wr_ent("R10 random write", k, rnd_ent());
        rnd_lookups(300);

        finish_run();
    end
endmodule